// File: doc/BRIEF.md
# Multi-Group Page Translation Cache

This block keeps recently used page-table words next to the address path, so that a repeated reference to a virtual page is answered without walking the table in memory. A lookup presents an 8-bit virtual page number and a user/exec bit. One cycle later the block raises either a hit, with the cached mapping word and the bank that supplied it, or a one-cycle miss. On a miss the external walker fetches the page word and hands it back through the refill port.

Storage is split into three banks of sixteen entries. The main bank is fully associative and is tagged with the page number plus the user bit. A ring pointer chooses the victim on each refill. Each of two auxiliary banks owns one 16-page region, named by a 5-bit region key. A refill whose page falls in a claimed region goes into that bank at the slot given by the low four page bits, and the main bank is left alone. This keeps a hot region, such as code or a data table, from churning the main bank. A load command sets both keys and a 4-bit age value and returns the ring pointer to zero. The age value is presented to the walker for the age field of the page words it refills. A flush command invalidates every entry.

Top module: `pxb_top`

## Requirements
- R1: In the cycle after a cycle with `lookupValid` high, exactly one of `hitOut` and `missOut` is high. In the cycle after a cycle with `lookupValid` low, both are low.
- R2: A refill that lands in the main bank writes the entry at `ringPtr`, and `ringPtr` then steps by one modulo 16. A refill steered to an auxiliary bank, a flush, or an idle cycle leaves `ringPtr` unchanged.
- R3: A main-bank entry hits only when both the page number and the user bit equal the stored tag. The same page looked up with the other user bit misses. A main hit reports `hitSrc` = 0 and the stored word on `hitData`.
- R4: Key k is bits [5k+4:5k] of `loadKeys`. Bit 4 of a key is the user bit and bits 3:0 match page bits 7:4. A refill inside the region of key k is stored in auxiliary bank k at slot page[3:0], and a later lookup of that page reports `hitSrc` = k+1.
- R5: When several banks could answer a lookup, a valid auxiliary entry beats a main-bank hit. Among the auxiliary banks, the lowest-numbered one with a matching key and a valid slot wins. A refill matching both keys goes to bank 0 only.
- R6: A refill of a page already valid in the main bank writes the new word at `ringPtr` and invalidates the older copy, so a later lookup returns only the new word.
- R7: `flushReq` invalidates every entry of all three banks, effective for lookups in the following cycle. A refill presented in the same cycle is dropped.
- R8: `stateLoad` loads both keys and the age value and sets `ringPtr` to 0. This takes precedence over a main-bank refill in the same cycle, although that refill is still written at the old pointer.
- R9: `ageOut` presents the age value from the most recent `stateLoad`.
- R10: After reset: all entries are invalid, `ringPtr` = 0, `ageOut` = 0, `hitOut` = `missOut` = 0, and both keys are zero, so that exec pages 0x00 to 0x0F are claimed by auxiliary bank 0.
- R11: A lookup in the same cycle as a refill of the same page sees the contents from before that refill and misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupPage | input | 8 | Virtual page number to translate |
| lookupUser | input | 1 | 1 = user space, 0 = exec space |
| refillValid | input | 1 | Walker delivers a page word this cycle |
| refillPage | input | 8 | Virtual page of the refill |
| refillUser | input | 1 | User/exec bit of the refill |
| refillData | input | 18 | Page word to cache |
| flushReq | input | 1 | Invalidate every entry |
| stateLoad | input | 1 | Load keys and age, zero the ring pointer |
| loadKeys | input | 10 | Two 5-bit region keys, bank 0 in the low bits |
| loadAge | input | 4 | Age value to load |
| hitOut | output | 1 | Lookup hit, one cycle after the request |
| missOut | output | 1 | Lookup miss, one cycle after the request |
| hitSrc | output | 2 | Answering bank: 0 main, 1 aux 0, 2 aux 1 |
| hitData | output | 18 | Cached page word on a hit |
| ringPtr | output | 4 | Next main-bank victim slot |
| ageOut | output | 4 | Current age value for refills |

## Verification
The bench builds the block with its default shape: a 16-entry main bank, two auxiliary banks, 8-bit pages and 18-bit words. With these sizes the ring pointer wraps after a short run of refills, so eviction of the oldest entry falls inside a brief directed sequence. Two keys are enough to make equal keys, overlapping main and auxiliary copies, and a key region moved away from valid entries, so both priority orders and the reset-time claim of exec pages 0 to 15 can be reached.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  localparam int PAGE_W  = 8;
  localparam int SLOT_W  = 4;
  localparam int MAIN_N  = 16;
  localparam int NUM_AUX = 2;
  localparam int AUX_N   = 1 << SLOT_W;
  localparam int REG_W   = PAGE_W - SLOT_W;
  localparam int KEY_W   = REG_W + 1;
  localparam int PTR_W   = $clog2(MAIN_N);
  localparam int SRC_W   = $clog2(NUM_AUX + 1);

  typedef struct packed {
    logic               flush;
    logic               wrMain;
    logic [NUM_AUX-1:0] wrAux;
    logic [PTR_W-1:0]   mainSlot;
  } strobe_t;
endpackage

// File: rtl/pxb_ctrl.sv
module pxb_ctrl
  import pxb_pkg::*;
#(
  parameter int AgeWidth = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             refillValid,
  input  logic [KEY_W-1:0]                 refRegion,
  input  logic                             flushReq,
  input  logic                             stateLoad,
  input  logic [NUM_AUX*KEY_W-1:0]         loadKeys,
  input  logic [AgeWidth-1:0]              loadAge,
  output strobe_t                          strb,
  output logic [NUM_AUX-1:0][KEY_W-1:0]    keyVec,
  output logic [PTR_W-1:0]                 ringPtr,
  output logic [AgeWidth-1:0]              ageOut
);
  logic [NUM_AUX-1:0] claimed;
  logic [PTR_W-1:0]   ptrQ;

  // lowest-numbered bank whose key covers the refill region claims it
  always_comb begin
    claimed = '0;
    for (int a = NUM_AUX - 1; a >= 0; a--) begin
      if (keyVec[a] == refRegion) begin
        claimed    = '0;
        claimed[a] = 1'b1;
      end
    end
    strb.flush    = flushReq;
    strb.wrAux    = (refillValid && !flushReq) ? claimed : '0;
    strb.wrMain   = refillValid && !flushReq && (claimed == '0);
    strb.mainSlot = ptrQ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptrQ   <= '0;
      keyVec <= '0;
      ageOut <= '0;
    end else if (stateLoad) begin
      ptrQ   <= '0;
      keyVec <= loadKeys;
      ageOut <= loadAge;
    end else if (strb.wrMain) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  assign ringPtr = ptrQ;
endmodule

// File: rtl/pxb_datapath.sv
module pxb_datapath
  import pxb_pkg::*;
#(
  parameter int DataWidth = 18
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  strobe_t                       strb,
  input  logic [NUM_AUX-1:0][KEY_W-1:0] keyVec,
  input  logic                          lookupValid,
  input  logic [PAGE_W-1:0]             lookupPage,
  input  logic                          lookupUser,
  input  logic [PAGE_W-1:0]             refillPage,
  input  logic                          refillUser,
  input  logic [DataWidth-1:0]          refillData,
  output logic                          hitOut,
  output logic                          missOut,
  output logic [SRC_W-1:0]              hitSrc,
  output logic [DataWidth-1:0]          hitData
);
  logic [MAIN_N-1:0]              mainVal;
  logic [PAGE_W:0]                mainTag  [MAIN_N];
  logic [DataWidth-1:0]           mainData [MAIN_N];
  logic [NUM_AUX-1:0][AUX_N-1:0]  auxVal;
  logic [DataWidth-1:0]           auxData  [NUM_AUX][AUX_N];

  logic [PAGE_W:0]      lkTag, refTag;
  logic [KEY_W-1:0]     lkRegion;
  logic [SLOT_W-1:0]    lkSlot, refSlot;
  logic [MAIN_N-1:0]    mainHit, refDup;
  logic [NUM_AUX-1:0]   auxHit;
  logic [DataWidth-1:0] auxWord [NUM_AUX];
  logic                 selHit;
  logic [SRC_W-1:0]     selSrc;
  logic [DataWidth-1:0] selData;

  assign lkTag    = {lookupUser, lookupPage};
  assign refTag   = {refillUser, refillPage};
  assign lkRegion = {lookupUser, lookupPage[PAGE_W-1:SLOT_W]};
  assign lkSlot   = lookupPage[SLOT_W-1:0];
  assign refSlot  = refillPage[SLOT_W-1:0];

  for (genvar i = 0; i < MAIN_N; i++) begin : g_main
    assign mainHit[i] = mainVal[i] && (mainTag[i] == lkTag);
    assign refDup[i]  = mainVal[i] && (mainTag[i] == refTag);
  end

  for (genvar a = 0; a < NUM_AUX; a++) begin : g_aux
    assign auxHit[a]  = (keyVec[a] == lkRegion) && auxVal[a][lkSlot];
    assign auxWord[a] = auxData[a][lkSlot];

    always_ff @(posedge clk) begin
      if (strb.wrAux[a]) auxData[a][refSlot] <= refillData;
    end
  end

  always_comb begin
    selHit  = |mainHit;
    selSrc  = '0;
    selData = '0;
    for (int i = 0; i < MAIN_N; i++) begin
      if (mainHit[i]) selData = selData | mainData[i];
    end
    for (int a = NUM_AUX - 1; a >= 0; a--) begin
      if (auxHit[a]) begin
        selHit  = 1'b1;
        selSrc  = SRC_W'(a + 1);
        selData = auxWord[a];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || strb.flush) begin
      mainVal <= '0;
      auxVal  <= '0;
    end else begin
      if (strb.wrMain) begin
        mainVal <= mainVal & ~refDup;
        mainVal[strb.mainSlot] <= 1'b1;
      end
      for (int a = 0; a < NUM_AUX; a++) begin
        if (strb.wrAux[a]) auxVal[a][refSlot] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrMain) begin
      mainTag[strb.mainSlot]  <= refTag;
      mainData[strb.mainSlot] <= refillData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hitOut  <= 1'b0;
      missOut <= 1'b0;
      hitSrc  <= '0;
      hitData <= '0;
    end else begin
      hitOut  <= lookupValid && selHit;
      missOut <= lookupValid && !selHit;
      if (lookupValid && selHit) begin
        hitSrc  <= selSrc;
        hitData <= selData;
      end
    end
  end
endmodule

// File: rtl/pxb_top.sv
module pxb_top
  import pxb_pkg::*;
#(
  parameter int DataWidth = 18,
  parameter int AgeWidth  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lookupValid,
  input  logic [PAGE_W-1:0]        lookupPage,
  input  logic                     lookupUser,
  input  logic                     refillValid,
  input  logic [PAGE_W-1:0]        refillPage,
  input  logic                     refillUser,
  input  logic [DataWidth-1:0]     refillData,
  input  logic                     flushReq,
  input  logic                     stateLoad,
  input  logic [NUM_AUX*KEY_W-1:0] loadKeys,
  input  logic [AgeWidth-1:0]      loadAge,
  output logic                     hitOut,
  output logic                     missOut,
  output logic [SRC_W-1:0]         hitSrc,
  output logic [DataWidth-1:0]     hitData,
  output logic [PTR_W-1:0]         ringPtr,
  output logic [AgeWidth-1:0]      ageOut
);
  strobe_t                       strb;
  logic [NUM_AUX-1:0][KEY_W-1:0] keyVec;
  logic [KEY_W-1:0]              refRegion;

  assign refRegion = {refillUser, refillPage[PAGE_W-1:SLOT_W]};

  pxb_ctrl #(.AgeWidth(AgeWidth)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .refillValid(refillValid), .refRegion(refRegion),
    .flushReq(flushReq), .stateLoad(stateLoad), .loadKeys(loadKeys),
    .loadAge(loadAge), .strb(strb), .keyVec(keyVec), .ringPtr(ringPtr),
    .ageOut(ageOut)
  );

  pxb_datapath #(.DataWidth(DataWidth)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .keyVec(keyVec),
    .lookupValid(lookupValid), .lookupPage(lookupPage), .lookupUser(lookupUser),
    .refillPage(refillPage), .refillUser(refillUser), .refillData(refillData),
    .hitOut(hitOut), .missOut(missOut), .hitSrc(hitSrc), .hitData(hitData)
  );
endmodule

// File: rtl/pxb_checker.sv
module pxb_checker
  import pxb_pkg::*;
#(
  parameter int AgeWidth = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                lookupValid,
  input logic                flushReq,
  input logic                stateLoad,
  input logic [AgeWidth-1:0] loadAge,
  input logic                hitOut,
  input logic                missOut,
  input logic [PTR_W-1:0]    ringPtr,
  input logic [AgeWidth-1:0] ageOut,
  input logic                wrMain,
  input logic [NUM_AUX-1:0]  wrAux
);
  assert_one_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid |=> (hitOut ^ missOut));

  assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !lookupValid |=> (!hitOut && !missOut));

  assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wrMain && !stateLoad) |=> (ringPtr == PTR_W'($past(ringPtr) + 1)));

  assert_ptr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrMain && !stateLoad) |=> $stable(ringPtr));

  assert_single_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wrMain, wrAux}));

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flushReq) && lookupValid) |=> missOut);

  assert_no_write_on_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flushReq |-> (!wrMain && wrAux == '0));

  assert_ptr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stateLoad |=> (ringPtr == '0));

  assert_age_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stateLoad |=> (ageOut == $past(loadAge)));
endmodule

bind pxb_top pxb_checker #(.AgeWidth(AgeWidth)) u_chk (
  .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid), .flushReq(flushReq),
  .stateLoad(stateLoad), .loadAge(loadAge), .hitOut(hitOut), .missOut(missOut),
  .ringPtr(ringPtr), .ageOut(ageOut), .wrMain(strb.wrMain), .wrAux(strb.wrAux)
);

// File: tb/tb_pxb_top.sv
module tb_pxb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lookupValid, lookupUser, refillValid, refillUser, flushReq, stateLoad;
  logic [7:0]  lookupPage, refillPage;
  logic [17:0] refillData;
  logic [9:0]  loadKeys;
  logic [3:0]  loadAge;
  logic        hitOut, missOut;
  logic [1:0]  hitSrc;
  logic [17:0] hitData;
  logic [3:0]  ringPtr, ageOut;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // behavioural reference state
  bit         mVal  [16];
  int         mTag  [16];
  int         mData [16];
  bit         aVal  [2][16];
  int         aData [2][16];
  int         mKey  [2];
  int         mPtr, mAge;

  always #4 clk = ~clk;

  pxb_top dut (
    .clk(clk), .rst_n(rst_n), .lookupValid(lookupValid), .lookupPage(lookupPage),
    .lookupUser(lookupUser), .refillValid(refillValid), .refillPage(refillPage),
    .refillUser(refillUser), .refillData(refillData), .flushReq(flushReq),
    .stateLoad(stateLoad), .loadKeys(loadKeys), .loadAge(loadAge),
    .hitOut(hitOut), .missOut(missOut), .hitSrc(hitSrc), .hitData(hitData),
    .ringPtr(ringPtr), .ageOut(ageOut)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clearIn();
    lookupValid = 0; lookupPage = 0; lookupUser = 0;
    refillValid = 0; refillPage = 0; refillUser = 0; refillData = 0;
    flushReq = 0; stateLoad = 0; loadKeys = 0; loadAge = 0;
  endtask

  // computes expected outputs from the pre-edge model, updates the model,
  // waits one cycle and compares at the falling edge
  task automatic step(input string tag);
    bit eHit = 0;
    int eSrc = 0, eData = 0;
    int lTag = {lookupUser, lookupPage};
    int lReg = {lookupUser, lookupPage[7:4]};
    int rTag = {refillUser, refillPage};
    int rReg = {refillUser, refillPage[7:4]};
    int bank;
    if (lookupValid) begin
      for (int i = 0; i < 16; i++)
        if (mVal[i] && mTag[i] == lTag) begin eHit = 1; eSrc = 0; eData = mData[i]; end
      for (int a = 1; a >= 0; a--)
        if (mKey[a] == lReg && aVal[a][lookupPage[3:0]]) begin
          eHit = 1; eSrc = a + 1; eData = aData[a][lookupPage[3:0]];
        end
    end
    if (flushReq) begin
      for (int i = 0; i < 16; i++) begin mVal[i] = 0; aVal[0][i] = 0; aVal[1][i] = 0; end
    end else if (refillValid) begin
      bank = -1;
      for (int a = 1; a >= 0; a--) if (mKey[a] == rReg) bank = a;
      if (bank >= 0) begin
        aVal[bank][refillPage[3:0]]  = 1;
        aData[bank][refillPage[3:0]] = refillData;
      end else begin
        for (int i = 0; i < 16; i++) if (mVal[i] && mTag[i] == rTag) mVal[i] = 0;
        mVal[mPtr] = 1; mTag[mPtr] = rTag; mData[mPtr] = refillData;
        mPtr = (mPtr + 1) % 16;
      end
    end
    if (stateLoad) begin
      mKey[0] = loadKeys[4:0]; mKey[1] = loadKeys[9:5]; mAge = loadAge; mPtr = 0;
    end
    @(negedge clk);
    check(tag, hitOut,  eHit,  "hitOut");
    check(tag, missOut, lookupValid && !eHit, "missOut");
    if (eHit) begin
      check(tag, hitSrc,  eSrc,  "hitSrc");
      check(tag, hitData, eData, "hitData");
    end
    check(tag, ringPtr, mPtr, "ringPtr");
    check(tag, ageOut,  mAge, "ageOut");
    clearIn();
  endtask

  task automatic look(input string tag, input int page, input bit user);
    lookupValid = 1; lookupPage = page[7:0]; lookupUser = user; step(tag);
  endtask

  task automatic fill(input string tag, input int page, input bit user, input int data);
    refillValid = 1; refillPage = page[7:0]; refillUser = user; refillData = data[17:0];
    step(tag);
  endtask

  task automatic load(input string tag, input int k0, input int k1, input int age);
    stateLoad = 1; loadKeys = {k1[4:0], k0[4:0]}; loadAge = age[3:0]; step(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    clearIn();
    rst_n = 0;
    for (int i = 0; i < 16; i++) begin mVal[i] = 0; aVal[0][i] = 0; aVal[1][i] = 0; end
    mKey[0] = 0; mKey[1] = 0; mPtr = 0; mAge = 0;
    repeat (3) @(negedge clk);
    check("R10", hitOut, 0, "hitOut in reset");
    check("R10", missOut, 0, "missOut in reset");
    check("R10", ringPtr, 0, "ringPtr in reset");
    check("R10", ageOut, 0, "ageOut in reset");
    rst_n = 1;
    step("R1");                              // idle: both outputs low
    look("R10", 8'h05, 0);                   // empty: miss
    fill("R10", 8'h05, 0, 18'h01234);        // zero keys claim exec 0x00-0x0F
    look("R10", 8'h05, 0);                   // aux bank 0 answers
    look("R1", 8'h05, 1);                    // user copy not present
    // R8 R9: load keys user 0xA_, exec 0x3_; age 5
    load("R8", 5'h1A, 5'h03, 5);
    look("R9", 8'h05, 0);                    // region moved: miss
    // R2 R3: main bank refills
    fill("R2", 8'h40, 1, 18'h00111);
    fill("R2", 8'h40, 0, 18'h00222);
    fill("R2", 8'h41, 1, 18'h00333);
    look("R3", 8'h40, 1);
    look("R3", 8'h40, 0);
    look("R3", 8'h41, 0);                    // other user bit: miss
    // R4: steering into auxiliary banks, pointer holds
    fill("R4", 8'hA7, 1, 18'h0AAAA);
    fill("R4", 8'h35, 0, 18'h03535);
    look("R4", 8'hA7, 1);
    look("R4", 8'h35, 0);
    look("R4", 8'hA8, 1);                    // other slot empty
    // R11: same-cycle lookup and refill
    lookupValid = 1; lookupPage = 8'h77; lookupUser = 1;
    refillValid = 1; refillPage = 8'h77; refillUser = 1; refillData = 18'h07777;
    step("R11");
    look("R11", 8'h77, 1);
    // R6: duplicate refill, disjoint data bits
    fill("R6", 8'h50, 0, 18'h00F0F);
    fill("R6", 8'h50, 0, 18'h030F0);
    look("R6", 8'h50, 0);
    // R5: aux beats main
    fill("R5", 8'hB2, 1, 18'h0B0B0);
    look("R5", 8'hB2, 1);
    load("R5", 5'h1A, 5'h1B, 6);
    fill("R5", 8'hB2, 1, 18'h1B1B1);
    look("R5", 8'hB2, 1);
    // R5: equal keys, lower bank wins
    load("R5", 5'h07, 5'h06, 6);
    fill("R5", 8'h63, 0, 18'h06363);        // into aux1
    load("R5", 5'h06, 5'h06, 7);
    look("R5", 8'h63, 0);                    // only aux1 valid
    fill("R5", 8'h63, 0, 18'h16363);        // into aux0 only
    look("R5", 8'h63, 0);
    // R2: wrap the ring pointer and evict the oldest entries
    for (int i = 0; i < 18; i++) fill("R2", 8'hC0 + i, 0, 18'h20000 + i);
    look("R2", 8'hC0, 0);                    // overwritten by the wrap
    look("R2", 8'hC2, 0);
    look("R2", 8'hD1, 0);
    // R8: load with simultaneous main refill
    stateLoad = 1; loadKeys = {5'h06, 5'h06}; loadAge = 4'h9;
    refillValid = 1; refillPage = 8'hE1; refillUser = 1; refillData = 18'h0E1E1;
    step("R8");
    look("R8", 8'hE1, 1);
    fill("R8", 8'hE2, 1, 18'h0E2E2);
    // R7: flush with a concurrent refill
    flushReq = 1; refillValid = 1; refillPage = 8'hE3; refillUser = 1; refillData = 18'h0E3E3;
    step("R7");
    look("R7", 8'hE1, 1);
    look("R7", 8'hE3, 1);
    look("R7", 8'h63, 0);
    fill("R7", 8'hE4, 1, 18'h0E4E4);
    look("R7", 8'hE4, 1);
    step("R1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule